// File: doc/BRIEF.md
# Failsafe Watchdog Timer with Early Warning

This block supervises a host that must prove it is alive by pulling an active-low service input low at regular intervals. When a full timeout period passes with no service, an active-low warning output drops so that the host can attempt a recovery. If the host stays silent for the whole of that low phase, an active-low reset output falls and latches. From then on the warning output runs as a square wave whose period is twice the timeout. Only a valid service pulse or a fresh power-up sequence releases the latched reset.

The period is counted in system clock cycles. The default corresponds to 10 ms at a 100 MHz clock. The service input is asynchronous. It passes through a two-flop synchronizer and must then stay low for a minimum number of clock samples before it counts. The default minimum is 150 ns at 100 MHz. Two inputs from the supply sequencer gate the whole block. One says the supplies are good. The other says the power-on delay has finished. While either is low, the timer is held and the outputs are parked: warning inactive, reset active.

Top module: `fs_watchdog`

## Requirements
- R1: While `run_en` or `por_done` is low, the block is disarmed. The clock edge that samples this state drives `warn_n` to 1 and `rst_n` to 0, and the period count restarts from zero.
- R2: On the first clock edge that samples the block armed, `rst_n` goes to 1. With no service, `warn_n` goes to 0 after exactly `TIMEOUT_CYC` armed edges, counting the first one.
- R3: Without service, `warn_n` inverts every `TIMEOUT_CYC` edges. This gives a square wave of period 2×`TIMEOUT_CYC` that begins with a low phase. The wave is the same whether the service input is held high or held low.
- R4: If no service is accepted during the first low phase of `warn_n`, `rst_n` goes to 0 on the same edge where `warn_n` returns to 1. It then stays 0 through every later phase.
- R5: After two synchronizer flops, a service request is accepted only when `clr_n` reads 0 on at least `MINLOW_CYC` consecutive clock edges. Each low episode yields at most one acceptance, and a rising edge of `clr_n` never yields one. If the first low sample is taken at edge a, the acceptance acts on edge a+`MINLOW_CYC`+2.
- R6: An accepted service while armed sets both `warn_n` and `rst_n` to 1 and restarts the period count from zero. Service at intervals shorter than `TIMEOUT_CYC` keeps both outputs at 1 indefinitely.
- R7: A service request accepted while the block is disarmed has no effect. After re-arming, the timing starts afresh as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time base of the period counter |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low service request from the host |
| run_en | input | 1 | High while the supplies are in range |
| por_done | input | 1 | High once the power-on delay has elapsed |
| warn_n | output | 1 | Registered active-low timeout warning |
| rst_n | output | 1 | Registered active-low latched reset |

## Verification
The bench targets the exact edges where the warning falls, rises and latches the reset. A timer that is off by one cycle would move the warning edge, and a reset latched on the first falling edge instead of the first rising edge would fire a full period early. Service pulses of every width from one sample up to two beyond the minimum are swept. A filter that counts one sample too few accepts glitches, and one that counts one too many rejects legal pulses. A service input held low, and then released, must not restart the timer again, so a filter that also triggers on the rising edge would show a wrong phase. Service while the block is disarmed must leave the parked reset in place. Re-arming must restart the count from zero, so a counter that keeps its value across the disarmed time would warn too early.

// File: rtl/wd_pkg.sv
package wd_pkg;
  // What the phase controller does on a given clock edge
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,  // count on, nothing to update
    EV_SERVE  = 2'd1,  // accepted service request
    EV_EXPIRE = 2'd2,  // one full period has elapsed
    EV_PARK   = 2'd3   // block disarmed by the sequencer
  } wd_event_e;
endpackage

// File: rtl/wd_clr_filter.sv
module wd_clr_filter #(
  parameter int MINLOW_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  output logic accept
);
  localparam int LW = $clog2(MINLOW_CYC + 1);
  localparam logic [LW-1:0] LMAX = LW'(MINLOW_CYC);

  logic          meta_q, sync_q;
  logic [LW-1:0] low_q;
  logic          acc_q;

  // two-flop synchronizer, idles high
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= clr_n;
      sync_q <= meta_q;
    end
  end

  // saturating run-length of low samples; one acceptance per episode
  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
      acc_q <= 1'b0;
    end else begin
      acc_q <= !sync_q && (low_q == LMAX - 1'b1);
      if (sync_q)
        low_q <= '0;
      else if (low_q != LMAX)
        low_q <= low_q + 1'b1;
    end
  end

  assign accept = acc_q;

  // R5: an episode of low samples yields a single-cycle acceptance
  p_single_accept_r5: assert property (@(posedge clk) disable iff (rst)
    acc_q |=> !acc_q);
endmodule

// File: rtl/wd_period_timer.sv
module wd_period_timer #(
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || expire)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  // R3: every expiry starts the next period from zero
  p_expire_wraps_r3: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == '0));
  // R1: a disarmed edge leaves the count at zero
  p_park_clears_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/wd_phase_ctrl.sv
module wd_phase_ctrl
  import wd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic serve,
  input  logic expire,
  output logic warn_n,
  output logic rst_n
);
  wd_event_e ev;
  logic      warn_q, rstn_q, latched_q;

  always_comb begin
    if (!armed)      ev = EV_PARK;
    else if (serve)  ev = EV_SERVE;
    else if (expire) ev = EV_EXPIRE;
    else             ev = EV_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q    <= 1'b1;
      rstn_q    <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      case (ev)
        EV_PARK: begin
          warn_q    <= 1'b1;
          rstn_q    <= 1'b0;
          latched_q <= 1'b0;
        end
        EV_SERVE: begin
          warn_q    <= 1'b1;
          rstn_q    <= 1'b1;
          latched_q <= 1'b0;
        end
        EV_EXPIRE: begin
          warn_q <= !warn_q;
          if (!warn_q) begin
            // end of a low phase: the first one latches the reset
            latched_q <= 1'b1;
            rstn_q    <= 1'b0;
          end else begin
            rstn_q <= !latched_q;
          end
        end
        default: rstn_q <= !latched_q;
      endcase
    end
  end

  assign warn_n = warn_q;
  assign rst_n  = rstn_q;

  // R1: disarming parks the outputs
  p_park_outputs_r1: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (warn_q && !rstn_q));
  // R6: accepted service releases both outputs
  p_serve_release_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && serve) |=> (warn_q && rstn_q));
  // R4: while armed, reset only falls together with the rising warning
  p_latch_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(rstn_q) && $past(armed)) |-> $rose(warn_q));
  // R3: the warning only moves on an expiry, service or park
  p_warn_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !serve && !expire) |=> $stable(warn_q));
endmodule

// File: rtl/fs_watchdog.sv
module fs_watchdog #(
  parameter int TIMEOUT_CYC = 1000000,  // 10 ms at 100 MHz
  parameter int MINLOW_CYC  = 15        // 150 ns at 100 MHz
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic run_en,
  input  logic por_done,
  output logic warn_n,
  output logic rst_n
);
  logic armed, accept, expire;

  assign armed = run_en && por_done;

  wd_clr_filter #(.MINLOW_CYC(MINLOW_CYC)) u_filter (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (clr_n),
    .accept (accept)
  );

  wd_period_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (armed),
    .restart (accept),
    .expire  (expire)
  );

  wd_phase_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .armed  (armed),
    .serve  (accept),
    .expire (expire),
    .warn_n (warn_n),
    .rst_n  (rst_n)
  );
endmodule

// File: tb/test_fs_watchdog.sv
`timescale 1ns/1ps
module test_fs_watchdog;
  localparam int T = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst, clr_n, run_en, por_done;
  logic warn_n, rst_n;
  int   checks = 0;
  int   errors = 0;

  always #2.5 clk = ~clk;

  fs_watchdog #(.TIMEOUT_CYC(T), .MINLOW_CYC(W)) i_fs_watchdog (
    .clk(clk), .rst(rst), .clr_n(clr_n), .run_en(run_en),
    .por_done(por_done), .warn_n(warn_n), .rst_n(rst_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // n = edges since the serve edge (serve edge = 0) or since arming (first armed edge = 1)
  task automatic sweep(input int n0, input int count, input string req);
    for (int i = 0; i < count; i++) begin
      int n = n0 + i;
      chk(warn_n, ((n / T) % 2) == 0, (n < T) ? "R2" : "R3", $sformatf("%s warn_n n=%0d", req, n));
      chk(rst_n, n < 2 * T, "R4", $sformatf("%s rst_n n=%0d", req, n));
      tick();
    end
  endtask

  task automatic pulse(input int w);
    clr_n = 1'b0;
    repeat (w) tick();
    clr_n = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; clr_n = 1'b1; run_en = 1'b0; por_done = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(warn_n, 1'b1, "R1", "reset warn_n");
    chk(rst_n,  1'b0, "R1", "reset rst_n");

    // supplies good, power-on delay pending: still parked, service ignored (R7)
    run_en = 1'b1;
    repeat (2 * T) tick();
    chk(rst_n, 1'b0, "R1", "por pending rst_n");
    pulse(W);
    repeat (4) tick();
    chk(rst_n,  1'b0, "R7", "serve before por_done rst_n");
    chk(warn_n, 1'b1, "R7", "serve before por_done warn_n");

    // arm and let it run free: R2, R3, R4
    por_done = 1'b1;
    tick();
    sweep(1, 5 * T, "free-run");

    // service releases the latched reset (R6)
    pulse(W);
    repeat (3) tick();
    chk(warn_n, 1'b1, "R6", "serve warn_n");
    chk(rst_n,  1'b1, "R6", "serve rst_n");
    sweep(0, 3 * T, "after-serve");

    // regular service every 6 edges < T keeps both high (R6)
    pulse(W);
    repeat (3) tick();
    for (int k = 0; k < 10; k++) begin
      clr_n = 1'b0;
      for (int j = 0; j < 6; j++) begin
        if (j == W) clr_n = 1'b1;
        chk(warn_n, 1'b1, "R6", "serviced warn_n");
        chk(rst_n,  1'b1, "R6", "serviced rst_n");
        tick();
      end
    end

    // service input held low: one acceptance, then the wave (R3, R5)
    clr_n = 1'b0;
    repeat (W + 3) tick();
    sweep(0, 4 * T, "held-low R3");
    clr_n = 1'b1;
    sweep(4 * T, 2 * T, "release no-serve R5");

    // pulse-width sweep from a latched state (R5)
    for (int w = 1; w <= W + 2; w++) begin
      repeat (2 * T + 2) tick();
      chk(rst_n, 1'b0, "R4", $sformatf("latched before w=%0d", w));
      pulse(w);
      repeat (3) tick();
      chk(rst_n, (w >= W), "R5", $sformatf("rst_n after pulse w=%0d", w));
      if (w >= W) chk(warn_n, 1'b1, "R5", $sformatf("warn_n after pulse w=%0d", w));
    end

    // disarm while the warning is low (R1), then serve while disarmed (R7)
    pulse(W);
    repeat (3) tick();
    repeat (T + 1) tick();
    chk(warn_n, 1'b0, "R3", "warn low before disarm");
    run_en = 1'b0;
    tick();
    chk(warn_n, 1'b1, "R1", "disarm warn_n");
    chk(rst_n,  1'b0, "R1", "disarm rst_n");
    pulse(W);
    repeat (5) tick();
    chk(warn_n, 1'b1, "R7", "serve while disarmed warn_n");
    chk(rst_n,  1'b0, "R7", "serve while disarmed rst_n");

    // re-arm: fresh timing from zero (R7)
    run_en = 1'b1;
    tick();
    sweep(1, 3 * T, "re-arm R7");

    summary();
    $finish;
  end
endmodule